// File: doc/BRIEF.md
# Dithered PWM Timing Generator

This block is the digital timing core of a current-mode PWM controller. It runs on a fixed system clock and divides it into switching cycles. At the start of each cycle it raises the gate output. It drops the gate when the external current-sense comparator trips, or when a hard duty cap is reached, whichever comes first. A blanking window right after turn-on hides the comparator's turn-on spike. In normal load, the cycle length follows a slow triangular sweep around the nominal period, which spreads the switching spectrum.

Five feedback-level flags come from comparators on the feedback node. They pick the operating mode:
- normal dithered frequency;
- a fixed, longer green-mode period for light load;
- burst operation, where pulses are let through in small groups at a sub-audible grouping rate and the other cycles are skipped;
- off.

Off kills the gate at once. Every other change, whether of mode or of period, is taken only at a cycle boundary, so no truncated pulse is produced. All times are integer counts of the system clock set by parameters.

Top module: `pwm_dith_gen`

## Requirements
- R1: A cycle lasts exactly the period latched at its start. The period is NOM_PER plus the current dither offset in normal mode, and GREEN_PER in green, burst and off modes.
- R2: The dither offset starts at 0 after reset and rises first. It advances by DITH_STEP at each normal-mode cycle start. It turns around when a further step would exceed ±DITH_SPAN, so with span 4 and step 1 the periods run NOM, NOM+1 … NOM+4, NOM+3 … NOM-4, NOM-3 and so on. The offset holds in other modes.
- R3: With no comparator trip, the gate stays high for exactly (P*DUTY_NUM)>>DUTY_SHIFT clocks of a cycle of P clocks.
- R4: A trip is ignored while fewer than LEB_CLKS clocks of the cycle have passed. A trip held from turn-on gives an on-time of LEB_CLKS+1 clocks. A trip first presented after t high clocks, with t ≥ LEB_CLKS+1, ends the pulse after exactly t clocks.
- R5: Green mode is entered when the below-green flag is set. It is left only when the above-normal flag is set. With neither flag set, the current choice holds.
- R6: In burst mode, cycles run at GREEN_PER. A pulse is started only while group credits remain. GROUP_PULSES credits are granted every GROUP_PER clocks, so steady burst gives GROUP_PULSES pulses per group period.
- R7: Burst mode is entered on the burst-enter flag. It is left only on the burst-exit flag. With neither flag set, burst holds.
- R8: The off flag forces the gate low in the same clock. Releasing it mid-cycle does not restart the pulse. No pulse starts in a cycle whose start sees the flag.
- R9: A flag change mid-cycle never shortens or alters the running pulse or period. The new mode applies from the next cycle start. The gate never rises twice in one cycle.
- R10: During reset the gate is low. The first cycle starts on the first clock edge after reset is released, in normal mode with a zero dither offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_above_norm_i | input | 1 | Feedback above normal-frequency level |
| fb_below_green_i | input | 1 | Feedback below green-mode level |
| fb_burst_enter_i | input | 1 | Feedback below burst entry level |
| fb_burst_exit_i | input | 1 | Feedback above burst exit level |
| fb_off_i | input | 1 | Feedback pulled to the off level |
| cs_trip_i | input | 1 | Current-sense comparator reset request |
| gate_o | output | 1 | Gate drive command |

## Verification
A corrupted cycle counter or latched period shows at once as a wrong rise-to-rise spacing on the gate. A broken dither register shows within a few cycles, because the sequence of periods departs from the triangle. A wrong blanking or cap comparison changes the measured on-time of the very next pulse. A wrong mode or hysteresis state shows one cycle later, as a period of the other mode. A damaged credit counter only shows over whole group periods, as a wrong pulse count per window, so burst is judged by counts over several group periods.

// File: rtl/pwm_dith_pkg.sv
package pwm_dith_pkg;

    typedef enum logic [1:0] {
        MODE_NORM  = 2'd0,
        MODE_GREEN = 2'd1,
        MODE_BURST = 2'd2,
        MODE_OFF   = 2'd3
    } sw_mode_e;

    typedef struct packed {
        logic above_norm;
        logic below_green;
        logic burst_enter;
        logic burst_exit;
        logic off;
    } fb_flags_t;

    // on-time limit as a fraction NUM / 2**SHIFT of the period
    function automatic int duty_cap(input int per, input int num, input int shift);
        return (per * num) >>> shift;
    endfunction

    function automatic int pick_period(input sw_mode_e m, input int nom,
                                       input int offs, input int green);
        return (m == MODE_NORM) ? (nom + offs) : green;
    endfunction

endpackage

// File: rtl/pwm_dith_dither.sv
module pwm_dith_dither #(
    parameter int DITH_SPAN = 92,
    parameter int DITH_STEP = 1,
    parameter int OFF_W     = $clog2(DITH_SPAN + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adv_i,
    output logic signed [OFF_W-1:0] offset_o
);
    localparam logic signed [OFF_W-1:0] STEP_S = OFF_W'(DITH_STEP);

    logic signed [OFF_W-1:0] off_q;
    logic                    up_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
            up_q  <= 1'b1;
        end else if (adv_i) begin
            if (up_q) begin
                if (int'(off_q) + DITH_STEP > DITH_SPAN) begin
                    up_q  <= 1'b0;
                    off_q <= off_q - STEP_S;
                end else begin
                    off_q <= off_q + STEP_S;
                end
            end else begin
                if (int'(off_q) - DITH_STEP < -DITH_SPAN) begin
                    up_q  <= 1'b1;
                    off_q <= off_q + STEP_S;
                end else begin
                    off_q <= off_q - STEP_S;
                end
            end
        end
    end

    assign offset_o = off_q;

    // R2: the sweep never leaves its span
    p_dither_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(off_q) <= DITH_SPAN) && (int'(off_q) >= -DITH_SPAN));

endmodule

// File: rtl/pwm_dith_mode.sv
module pwm_dith_mode
    import pwm_dith_pkg::*;
#(
    parameter int GROUP_PER    = 125000,
    parameter int GROUP_PULSES = 4,
    parameter int GRP_W        = $clog2(GROUP_PER),
    parameter int CR_W         = $clog2(GROUP_PULSES + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  fb_flags_t fb_i,
    input  logic      boundary_i,
    output sw_mode_e  mode_nxt_o,
    output logic      credit_ok_o
);
    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUP_PER - 1);
    localparam logic [CR_W-1:0]  CR_FULL  = CR_W'(GROUP_PULSES);

    logic             grn_q;
    logic             bst_q;
    logic [GRP_W-1:0] grp_cnt;
    logic [CR_W-1:0]  credits;
    logic             grp_wrap;
    logic             consume;

    // hysteresis bands for green and burst selection
    always_ff @(posedge clk) begin
        if (rst) begin
            grn_q <= 1'b0;
            bst_q <= 1'b0;
        end else begin
            if (fb_i.above_norm)       grn_q <= 1'b0;
            else if (fb_i.below_green) grn_q <= 1'b1;
            if (fb_i.burst_enter)      bst_q <= 1'b1;
            else if (fb_i.burst_exit)  bst_q <= 1'b0;
        end
    end

    always_comb begin
        if (fb_i.off)   mode_nxt_o = MODE_OFF;
        else if (bst_q) mode_nxt_o = MODE_BURST;
        else if (grn_q) mode_nxt_o = MODE_GREEN;
        else            mode_nxt_o = MODE_NORM;
    end

    assign grp_wrap    = (grp_cnt == GRP_LAST);
    assign credit_ok_o = (credits != '0);
    assign consume     = boundary_i && (mode_nxt_o == MODE_BURST) && credit_ok_o;

    // group timer and pulse credits for burst grouping
    always_ff @(posedge clk) begin
        if (rst) begin
            grp_cnt <= '0;
            credits <= CR_FULL;
        end else begin
            grp_cnt <= grp_wrap ? '0 : grp_cnt + GRP_W'(1);
            if (grp_wrap)
                credits <= CR_FULL - CR_W'(consume);
            else if (consume)
                credits <= credits - CR_W'(1);
        end
    end

    // R6: credits never exceed one group's grant
    p_credit_bound_r6: assert property (@(posedge clk) disable iff (rst)
        credits <= CR_FULL);

    // R5: green is entered only on the below-green flag
    p_green_entry_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(grn_q) |-> $past(fb_i.below_green));

    // R7: burst is left only on the exit flag
    p_burst_exit_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(bst_q) |-> $past(fb_i.burst_exit));

endmodule

// File: rtl/pwm_dith_cycle.sv
module pwm_dith_cycle #(
    parameter int PER_W    = 12,
    parameter int LEB_CLKS = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] per_nxt_i,
    input  logic [PER_W-1:0] cap_nxt_i,
    input  logic             start_ok_i,
    input  logic             cs_trip_i,
    input  logic             off_i,
    output logic             boundary_o,
    output logic             gate_o
);
    localparam logic [PER_W-1:0] LEB_C = PER_W'(LEB_CLKS);
    localparam logic [PER_W-1:0] ONE   = PER_W'(1);

    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] cap_q;
    logic             gate_q;
    logic             boot_q;
    logic             end_pulse;

    assign boundary_o = boot_q || (cnt == per_q - ONE);
    assign end_pulse  = off_i || (cnt == cap_q - ONE) ||
                        (cs_trip_i && (cnt >= LEB_C));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            per_q  <= '0;
            cap_q  <= '0;
            gate_q <= 1'b0;
            boot_q <= 1'b1;
        end else if (boundary_o) begin
            boot_q <= 1'b0;
            cnt    <= '0;
            per_q  <= per_nxt_i;
            cap_q  <= cap_nxt_i;
            gate_q <= start_ok_i;
        end else begin
            cnt <= cnt + ONE;
            if (gate_q && end_pulse)
                gate_q <= 1'b0;
        end
    end

    assign gate_o = gate_q && !off_i;

    // R3: the gate is never high at or past the duty limit
    p_duty_cap_r3: assert property (@(posedge clk) disable iff (rst)
        gate_q |-> (cnt < cap_q));

    // R4: inside the blanking window only the cap or off can end a pulse
    p_blank_r4: assert property (@(posedge clk) disable iff (rst)
        (gate_q && !off_i && !boundary_o && (cnt < LEB_C) && (cnt + ONE < cap_q))
        |=> gate_q);

    // R9: a pulse only begins at count zero, once per cycle
    p_start_boundary_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_q) |-> (cnt == '0));

    // R8: off mid-cycle leaves the gate low for the rest of the cycle
    p_off_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (off_i && !boundary_o) |=> !gate_q);

endmodule

// File: rtl/pwm_dith_gen.sv
module pwm_dith_gen
    import pwm_dith_pkg::*;
#(
    parameter int NOM_PER      = 1538,
    parameter int DITH_SPAN    = 92,
    parameter int DITH_STEP    = 1,
    parameter int GREEN_PER    = 4000,
    parameter int LEB_CLKS     = 25,
    parameter int DUTY_NUM     = 3,
    parameter int DUTY_SHIFT   = 2,
    parameter int GROUP_PER    = 125000,
    parameter int GROUP_PULSES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fb_above_norm_i,
    input  logic fb_below_green_i,
    input  logic fb_burst_enter_i,
    input  logic fb_burst_exit_i,
    input  logic fb_off_i,
    input  logic cs_trip_i,
    output logic gate_o
);
    localparam int PER_W = $clog2(NOM_PER + DITH_SPAN + GREEN_PER + 1);
    localparam int OFF_W = $clog2(DITH_SPAN + 1) + 1;
    localparam int PER_MIN = (NOM_PER - DITH_SPAN < GREEN_PER) ? NOM_PER - DITH_SPAN : GREEN_PER;
    localparam int PER_MAX = (NOM_PER + DITH_SPAN > GREEN_PER) ? NOM_PER + DITH_SPAN : GREEN_PER;

    fb_flags_t               fb;
    sw_mode_e                mode_nxt;
    logic                    credit_ok;
    logic                    boundary;
    logic                    start_ok;
    logic                    dith_adv;
    logic signed [OFF_W-1:0] offset;
    int                      per_int;
    logic [PER_W-1:0]        per_nxt;
    logic [PER_W-1:0]        cap_nxt;

    assign fb = '{above_norm:  fb_above_norm_i,
                  below_green: fb_below_green_i,
                  burst_enter: fb_burst_enter_i,
                  burst_exit:  fb_burst_exit_i,
                  off:         fb_off_i};

    pwm_dith_mode #(
        .GROUP_PER   (GROUP_PER),
        .GROUP_PULSES(GROUP_PULSES)
    ) u_mode (
        .clk        (clk),
        .rst        (rst),
        .fb_i       (fb),
        .boundary_i (boundary),
        .mode_nxt_o (mode_nxt),
        .credit_ok_o(credit_ok)
    );

    assign dith_adv = boundary && (mode_nxt == MODE_NORM);

    pwm_dith_dither #(
        .DITH_SPAN(DITH_SPAN),
        .DITH_STEP(DITH_STEP),
        .OFF_W    (OFF_W)
    ) u_dither (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (dith_adv),
        .offset_o(offset)
    );

    assign per_int  = pick_period(mode_nxt, NOM_PER, int'(offset), GREEN_PER);
    assign per_nxt  = PER_W'(per_int);
    assign cap_nxt  = PER_W'(duty_cap(per_int, DUTY_NUM, DUTY_SHIFT));
    assign start_ok = (mode_nxt != MODE_OFF) &&
                      ((mode_nxt != MODE_BURST) || credit_ok);

    pwm_dith_cycle #(
        .PER_W   (PER_W),
        .LEB_CLKS(LEB_CLKS)
    ) u_cycle (
        .clk       (clk),
        .rst       (rst),
        .per_nxt_i (per_nxt),
        .cap_nxt_i (cap_nxt),
        .start_ok_i(start_ok),
        .cs_trip_i (cs_trip_i),
        .off_i     (fb_off_i),
        .boundary_o(boundary),
        .gate_o    (gate_o)
    );

    // R1: every latched period lies inside the legal range
    p_period_range_r1: assert property (@(posedge clk) disable iff (rst)
        boundary |-> ((per_int >= PER_MIN) && (per_int <= PER_MAX)));

endmodule

// File: tb/pwm_dith_gen_test.sv
module pwm_dith_gen_test;
    localparam int NOM   = 40;
    localparam int SPAN  = 4;
    localparam int GREEN = 100;
    localparam int LEB   = 5;
    localparam int GRP   = 1000;
    localparam int GP    = 3;

    // cs trip offset (0 = none), expected period, expected on-time; green mode
    localparam int NV = 6;
    localparam int VEC [0:NV-1][0:2] = '{
        '{0,  100, 75},
        '{1,  100, 6},
        '{5,  100, 6},
        '{6,  100, 6},
        '{30, 100, 30},
        '{80, 100, 75}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic f_norm = 1'b1, f_green = 1'b0, f_benter = 1'b0, f_bexit = 1'b1, f_off = 1'b0;
    logic cs = 1'b0;
    logic gate;

    int n_tests = 0, n_fail = 0;
    int ncyc = 0, rise_cnt = 0, rise_at = 0, per_meas = 0, on_meas = 0, on_run = 0;
    int cs_at = 0;
    logic gprev = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_dith_gen #(
        .NOM_PER(NOM), .DITH_SPAN(SPAN), .DITH_STEP(1), .GREEN_PER(GREEN),
        .LEB_CLKS(LEB), .DUTY_NUM(3), .DUTY_SHIFT(2),
        .GROUP_PER(GRP), .GROUP_PULSES(GP)
    ) uut (
        .clk(clk), .rst(rst),
        .fb_above_norm_i(f_norm), .fb_below_green_i(f_green),
        .fb_burst_enter_i(f_benter), .fb_burst_exit_i(f_bexit),
        .fb_off_i(f_off), .cs_trip_i(cs), .gate_o(gate)
    );

    // gate monitor and current-sense model
    always @(negedge clk) begin
        ncyc++;
        if (gate && !gprev) begin
            rise_cnt++;
            per_meas = ncyc - rise_at;
            rise_at  = ncyc;
            on_meas  = on_run;
            on_run   = 1;
        end else if (gate) begin
            on_run++;
        end
        gprev = gate;
        if (!gate)                              cs = 1'b0;
        else if (cs_at != 0 && on_run >= cs_at) cs = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_rises(input int n);
        int target = rise_cnt + n;
        int guard = 0;
        while (rise_cnt < target && guard < 5000) begin
            tick(1);
            guard++;
        end
        if (rise_cnt < target) chk(1'b0, "watch", rise_cnt, target);
    endtask

    task automatic count_rises(input int nclk, output int n);
        int start = rise_cnt;
        tick(nclk);
        n = rise_cnt - start;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
        finish_run();
    end

    initial begin
        int off_m, up_m, p, n;
        tick(4);
        chk(gate == 1'b0, "R10 gate low in reset", gate, 0);
        rst = 1'b0;

        // R2/R1/R3/R10: dithered normal periods from reset, full capped pulses
        off_m = 0;
        up_m  = 1;
        wait_rises(1);
        for (int i = 0; i < 18; i++) begin
            p = NOM + off_m;
            if (up_m == 1) begin
                if (off_m + 1 > SPAN) begin up_m = 0; off_m--; end else off_m++;
            end else begin
                if (off_m - 1 < -SPAN) begin up_m = 1; off_m++; end else off_m--;
            end
            wait_rises(1);
            chk(per_meas == p, "R2 dither period", per_meas, p);
            chk(on_meas == (p * 3) >> 2, "R3 duty cap", on_meas, (p * 3) >> 2);
        end

        // R9: request green mid-pulse; running cycle stays intact
        tick(3);
        f_norm  = 1'b0;
        f_green = 1'b1;
        wait_rises(1);
        chk(per_meas >= NOM - SPAN && per_meas <= NOM + SPAN, "R9 no truncated period", per_meas, NOM);
        chk(on_meas == (per_meas * 3) >> 2, "R9 no truncated pulse", on_meas, (per_meas * 3) >> 2);
        wait_rises(1);
        chk(per_meas == GREEN, "R1 green period", per_meas, GREEN);

        // table of sense-trip patterns in green mode (R4, R3, R1)
        for (int v = 0; v < NV; v++) begin
            cs_at = VEC[v][0];
            wait_rises(3);
            chk(per_meas == VEC[v][1], "R1 vector period", per_meas, VEC[v][1]);
            chk(on_meas == VEC[v][2], "R4 vector on-time", on_meas, VEC[v][2]);
        end
        cs_at = 0;
        wait_rises(2);

        // R5: green holds with neither flag, leaves on above-normal
        f_green = 1'b0;
        wait_rises(3);
        chk(per_meas == GREEN, "R5 green hysteresis hold", per_meas, GREEN);
        f_norm = 1'b1;
        wait_rises(3);
        chk(per_meas <= NOM + SPAN, "R5 back to normal", per_meas, NOM);
        f_norm  = 1'b0;
        f_green = 1'b1;
        wait_rises(3);

        // R8: off kills the gate at once, no restart on release mid-cycle
        wait_rises(1);
        f_off = 1'b1;
        #1;
        chk(gate == 1'b0, "R8 immediate off", gate, 0);
        tick(3);
        f_off = 1'b0;
        #1;
        chk(gate == 1'b0, "R8 no restart mid-cycle", gate, 0);
        wait_rises(1);
        chk(per_meas == GREEN, "R8 period kept", per_meas, GREEN);
        chk(on_meas == 1, "R8 pulse cut", on_meas, 1);
        f_off = 1'b1;
        count_rises(300, n);
        chk(n == 0, "R8 held off", n, 0);
        f_off = 1'b0;
        wait_rises(2);
        chk(per_meas == GREEN && on_meas == 75, "R8 resumes", on_meas, 75);

        // R6: burst grouping
        f_benter = 1'b1;
        f_bexit  = 1'b0;
        tick(1500);
        count_rises(4000, n);
        chk(n >= 4 * GP - 1 && n <= 4 * GP + 1, "R6 burst pulses per group", n, 4 * GP);

        // R7: burst holds with neither flag, exits on exit flag
        f_benter = 1'b0;
        tick(200);
        count_rises(4000, n);
        chk(n >= 4 * GP - 1 && n <= 4 * GP + 1, "R7 burst hysteresis hold", n, 4 * GP);
        f_bexit = 1'b1;
        tick(200);
        count_rises(4000, n);
        chk(n >= 39 && n <= 41, "R7 burst exit to green", n, 40);

        // R10: reset again mid-run
        rst = 1'b1;
        tick(3);
        chk(gate == 1'b0, "R10 gate low on reset", gate, 0);
        finish_run();
    end
endmodule